// File: doc/BRIEF.md
# GPIO Interrupt Status Latch Controller

This block is the interrupt front end for a bank of general-purpose input pins. Each pin goes through a two-flop synchronizer. A per-line detector then looks for either an edge or a level, with a selectable polarity. A detected event can be captured in a sticky status bit. A captured bit can be forwarded to one shared, registered summary interrupt.

Two independent per-line enables control capture and forwarding. The capture enable decides whether an event sets the status bit. The forward enable decides whether a set status bit reaches the summary output. With this split, software can stop a level line from re-capturing while it is masked. It can also keep capturing edges on a masked edge line, so that those edges are reported after unmasking.

Software uses a plain strobe register interface. Addresses 0 to NUM_LINES-1 hold each line's configuration. Address NUM_LINES reads the status vector, and a write to it acknowledges status bits with write-one-to-clear.

Top module: `gpio_irq_latch_ctrl`

## Requirements
- R1: After reset, every status bit, every configuration register and the summary output are 0.
- R2: The configuration word for line i sits at address i, in bits [3:0]. Bit 0 is the forward enable, bit 1 the capture enable, bit 2 selects level mode (0 selects edge mode) and bit 3 inverts the polarity (1 selects falling or low). When the capture enable is 0, a detected event leaves the status bit unchanged.
- R3: The summary output is 1 exactly one clock after any line has both its status bit and its forward enable at 1.
- R4: In level mode with capture enabled, an acknowledge issued while the input is still active leaves the status bit at 1.
- R5: In level mode with capture disabled, the line can be acknowledged while its input is active. After the input deasserts and capture is re-enabled, the status bit stays 0.
- R6: In edge mode with capture enabled and forwarding disabled, an edge sets the status bit without raising the summary output. Setting the forward enable later raises the summary output.
- R7: Reading address NUM_LINES returns the status vector, with line i in bit i. Writing 1 to bit i at that address clears status bit i, and bits written as 0 are left as they are.
- R8: Turning the capture enable on while an edge-mode input is already steady at its active value does not set the status bit.
- R9: With the polarity bit set, edge mode responds to a falling edge and not to a rising edge.
- R10: A pin change appears in the status bit 3 clock edges after it is applied, because it passes two synchronizer flops and then the status flop.
- R11: The summary output stays 1 while at least one forwarded status bit remains set, and it returns to 0 one clock after the last forwarded status bit clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_LINES | Asynchronous input pins |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the current address (combinational) |
| irq_summary | output | 1 | Registered summary interrupt |

## Verification
A corrupted status bit shows up on a status read and, if the line is forwarded, on the summary output one clock later. Broken synchronizer or edge-history state shows up as a missing latch three edges after a pin change, or as a false latch when the capture enable is switched on. A wrong priority between acknowledge and set shows up within one clock as a level line that reads 0 while its pin is still active.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic active_low;  // bit 3
    logic level_mode;  // bit 2
    logic latch_en;    // bit 1
    logic fwd_en;      // bit 0
  } line_cfg_t;

  // Qualifying event from current and previous synchronized samples.
  function automatic logic detect_event(line_cfg_t c, logic cur, logic prev);
    logic a_cur;
    logic a_prev;
    a_cur  = cur ^ c.active_low;
    a_prev = prev ^ c.active_low;
    return c.level_mode ? a_cur : (a_cur & ~a_prev);
  endfunction

  // Next status: a set beats an acknowledge.
  function automatic logic next_status(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_s,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ack,
  output line_cfg_t        cfg,
  output logic             status,
  output logic             evt
);
  logic prev_q;

  assign evt = detect_event(cfg, pin_s, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      prev_q <= 1'b0;
      status <= 1'b0;
    end else begin
      if (cfg_we) cfg <= line_cfg_t'(cfg_wdata);
      prev_q <= pin_s;  // tracked regardless of enables
      status <= next_status(status, evt & cfg.latch_en, ack);
    end
  end
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic [N-1:0] fwd_en,
  output logic         summary
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) summary <= 1'b0;
    else        summary <= |(status & fwd_en);
  end
endmodule

// File: rtl/gpio_irq_latch_ctrl.sv
module gpio_irq_latch_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = $clog2(NUM_LINES + 1),
  parameter int DATA_W    = (NUM_LINES > CFG_W) ? NUM_LINES : CFG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq_summary
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_LINES);

  logic [NUM_LINES-1:0] pin_s;
  logic [NUM_LINES-1:0] status_vec;
  logic [NUM_LINES-1:0] evt_vec;
  logic [NUM_LINES-1:0] latch_en_vec;
  logic [NUM_LINES-1:0] fwd_en_vec;
  logic [NUM_LINES-1:0] ack_vec;
  logic [NUM_LINES-1:0] cfg_we_vec;
  line_cfg_t [NUM_LINES-1:0] cfg_all;
  logic status_wr;

  gpio_irq_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  assign status_wr = wr_en && (addr == STATUS_ADDR);
  assign ack_vec   = status_wr ? wdata[NUM_LINES-1:0] : '0;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign cfg_we_vec[i]   = wr_en && (addr == ADDR_W'(i));
    assign latch_en_vec[i] = cfg_all[i].latch_en;
    assign fwd_en_vec[i]   = cfg_all[i].fwd_en;

    gpio_irq_line u_line (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]),
      .cfg_we(cfg_we_vec[i]), .cfg_wdata(wdata[CFG_W-1:0]),
      .ack(ack_vec[i]), .cfg(cfg_all[i]),
      .status(status_vec[i]), .evt(evt_vec[i])
    );
  end

  gpio_irq_summary #(.N(NUM_LINES)) u_sum (
    .clk(clk), .rst_n(rst_n), .status(status_vec),
    .fwd_en(fwd_en_vec), .summary(irq_summary)
  );

  always_comb begin
    rdata = '0;
    if (addr == STATUS_ADDR) begin
      rdata[NUM_LINES-1:0] = status_vec;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (addr == ADDR_W'(i)) rdata[CFG_W-1:0] = cfg_all[i];
      end
    end
  end
endmodule

// File: rtl/gpio_irq_latch_ctrl_chk.sv
module gpio_irq_latch_ctrl_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] status,
  input logic [NUM_LINES-1:0] line_evt,
  input logic [NUM_LINES-1:0] latch_en,
  input logic [NUM_LINES-1:0] fwd_en,
  input logic [NUM_LINES-1:0] ack,
  input logic                 summary
);
  // R3 / R11: summary follows gated status one clock later
  p_summary_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & fwd_en)) |=> summary);
  p_summary_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & fwd_en)) |=> !summary);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    // R2: an enabled event latches
    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_evt[i] && latch_en[i]) |=> status[i]);
    // R8: status rises only after an enabled event
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(line_evt[i] && latch_en[i]));
    // R7: acknowledge without a competing set clears
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !(line_evt[i] && latch_en[i])) |=> !status[i]);
  end
endmodule

bind gpio_irq_latch_ctrl gpio_irq_latch_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status_vec), .line_evt(evt_vec),
  .latch_en(latch_en_vec), .fwd_en(fwd_en_vec), .ack(ack_vec),
  .summary(irq_summary)
);

// File: tb/gpio_irq_latch_ctrl_bench.sv
module gpio_irq_latch_ctrl_bench;
  localparam int N  = 8;
  localparam int AW = $clog2(N + 1);
  localparam int DW = N;
  localparam logic [AW-1:0] ST = AW'(N);
  // configuration bits
  localparam logic [3:0] FWD = 4'b0001, LAT = 4'b0010, LVL = 4'b0100, INV = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_summary;
  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_latch_ctrl #(.NUM_LINES(N)) u_gpio_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_summary(irq_summary)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) wr(AW'(i), '0);
    pin_in = '0; cyc(4);
    wr(ST, '1); cyc(2);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(ST, d); check("R1 status", d, 0);
    rd(0, d);  check("R1 cfg", d, 0);
    check("R1 summary", irq_summary, 0);
  endtask

  task automatic t_edge_basic();
    logic [DW-1:0] d;
    wr(0, DW'(LAT | FWD));
    pin_in[0] = 1'b1;
    cyc(2); rd(ST, d); check("R10 not yet", d[0], 0);
    cyc(1); rd(ST, d); check("R10 latched", d[0], 1);
    cyc(1); check("R3 summary", irq_summary, 1);
    rd(0, d); check("R2 cfg readback", d, DW'(LAT | FWD));
    wr(ST, DW'(1)); rd(ST, d); check("R7 ack", d[0], 0);
    cyc(1); check("R11 summary drop", irq_summary, 0);
    clear_all();
  endtask

  task automatic t_no_latch();
    logic [DW-1:0] d;
    wr(1, DW'(FWD));
    pin_in[1] = 1'b1; cyc(6);
    rd(ST, d); check("R2 capture disabled", d[1], 0);
    check("R2 summary", irq_summary, 0);
    clear_all();
  endtask

  task automatic t_level_relatch();
    logic [DW-1:0] d;
    wr(2, DW'(LVL | LAT | FWD));
    pin_in[2] = 1'b1; cyc(5);
    wr(ST, DW'(1 << 2));
    rd(ST, d); check("R4 relatch", d[2], 1);
    cyc(1); rd(ST, d); check("R4 still set", d[2], 1);
    clear_all();
  endtask

  task automatic t_level_masked();
    logic [DW-1:0] d;
    wr(3, DW'(LVL | LAT | FWD));
    pin_in[3] = 1'b1; cyc(5);
    wr(3, DW'(LVL));
    wr(ST, DW'(1 << 3)); cyc(1);
    rd(ST, d); check("R5 ack while masked", d[3], 0);
    pin_in[3] = 1'b0; cyc(5);
    wr(3, DW'(LVL | LAT | FWD)); cyc(2);
    rd(ST, d); check("R5 no stale bit", d[3], 0);
    check("R5 summary", irq_summary, 0);
    clear_all();
  endtask

  task automatic t_edge_masked();
    logic [DW-1:0] d;
    wr(4, DW'(LAT));
    pin_in[4] = 1'b1; cyc(6);
    rd(ST, d); check("R6 latched masked", d[4], 1);
    check("R6 summary masked", irq_summary, 0);
    wr(4, DW'(LAT | FWD)); cyc(1);
    check("R6 summary unmasked", irq_summary, 1);
    clear_all();
  endtask

  task automatic t_enable_toggle();
    logic [DW-1:0] d;
    pin_in[5] = 1'b1; cyc(6);
    wr(5, DW'(LAT | FWD)); cyc(4);
    rd(ST, d); check("R8 no spurious latch", d[5], 0);
    wr(5, DW'(FWD)); wr(5, DW'(LAT | FWD)); cyc(4);
    rd(ST, d); check("R8 retoggle", d[5], 0);
    clear_all();
  endtask

  task automatic t_falling();
    logic [DW-1:0] d;
    wr(6, DW'(INV | LAT | FWD));
    pin_in[6] = 1'b1; cyc(6);
    rd(ST, d); check("R9 rising ignored", d[6], 0);
    pin_in[6] = 1'b0; cyc(6);
    rd(ST, d); check("R9 falling latched", d[6], 1);
    clear_all();
  endtask

  task automatic t_multi();
    logic [DW-1:0] d;
    wr(0, DW'(LAT | FWD)); wr(7, DW'(LAT | FWD));
    pin_in[0] = 1'b1; pin_in[7] = 1'b1; cyc(6);
    rd(ST, d); check("R7 two bits", d, DW'(8'h81));
    wr(ST, DW'(1)); cyc(1);
    rd(ST, d); check("R7 partial ack", d, DW'(8'h80));
    check("R11 summary held", irq_summary, 1);
    wr(ST, DW'(8'h80)); cyc(1);
    check("R11 summary low", irq_summary, 0);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_edge_basic();
    t_no_latch();
    t_level_relatch();
    t_level_masked();
    t_edge_masked();
    t_enable_toggle();
    t_falling();
    t_multi();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule